// File: doc/BRIEF.md
# Station Address Receive Filter

This block decides, early in a frame, whether the frame should be kept. It watches a byte stream carrying a start-of-frame marker and a byte-valid qualifier. It compares the first six bytes against a 48-bit station address and also checks them against the all-ones broadcast address. A 2-bit accept mode then combines the two outcomes into a keep/drop decision. The decision is reported as a one-cycle done pulse together with an accept flag.

The station address and the accept mode are loaded through a small write-only register port. Offsets 0 to 5 each hold one address byte, and offset 6 holds the mode. Offset 0 is compared against the first destination byte on the wire and offset 5 against the sixth. Checking frame integrity, storing frames and filtering by group hash are left to neighbouring blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: Writing `cfg_wdata` at `cfg_addr` 0..5 loads station byte 0..5. Station byte k is compared with the k-th byte of the frame, counting from 0 at the start-of-frame byte. A write to any one offset changes only that byte's comparison.
- R2: A write to `cfg_addr` 6 loads the accept mode from `cfg_wdata[1:0]`. In mode 0 every frame is rejected: `dec_accept` stays 0 when `dec_done` pulses.
- R3: In mode 1 a frame is accepted only when all six destination bytes equal the station bytes. Broadcast and any mismatch are rejected.
- R4: In mode 2 a frame is accepted when its destination equals the station address or is all ones (six bytes of 0xFF). Any other destination is rejected.
- R5: In mode 3 every frame that reaches its sixth byte is accepted, whatever its destination.
- R6: `dec_done` is high for exactly one cycle: the cycle after the clock edge that samples the sixth valid byte. `dec_accept` carries the decision in that cycle and is 0 whenever `dec_done` is 0. Cycles with `rx_valid` low between bytes are not counted.
- R7: A byte presented with `rx_valid` and `rx_sof` both high is byte 0 of a new frame. It discards any partially compared frame, which then produces no decision.
- R8: A frame of fewer than six valid bytes produces no `dec_done`. Valid bytes after the sixth, and valid bytes before any start-of-frame, produce no `dec_done`.
- R9: After reset `dec_done` and `dec_accept` are 0, the station bytes are 0 and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset: 0..5 station bytes, 6 accept mode |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Byte on `rx_byte` is valid this cycle |
| rx_sof | input | 1 | Valid byte is the first of a frame |
| rx_byte | input | 8 | Received frame byte |
| dec_done | output | 1 | One-cycle pulse: the decision is available |
| dec_accept | output | 1 | Frame accepted, qualified by `dec_done` |

## Verification
The hardest case to reach from the ports is a frame cut short and immediately replaced. The partial comparison state must vanish without a decision, and the new frame must then be judged only on its own bytes. The stimulus sends four start-of-frame-led bytes that already match the station prefix, then restarts with a matching frame. It also sends a run of valid bytes that has no start marker and a run of trailing bytes after a completed frame. In every case the bench watches `dec_done` on each intervening cycle. Idle cycles are inserted between bytes so that the counter is shown to advance only on valid bytes.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              dec_done,
  output logic              dec_accept
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDLE = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [2:0] MODE_OFS = 3'(ADDR_BYTES);

  logic [BYTE_W-1:0] sta_q [ADDR_BYTES];
  logic [1:0]        mode_q;
  logic [IDX_W-1:0]  idx_q, cur_idx;
  logic              phys_q, bc_q, phys_n, bc_n, byte_hit, verdict;
  logic              done_q, accept_q;

  wire first = rx_valid & rx_sof;
  wire live  = rx_valid & ~rx_sof & (idx_q != IDLE);
  wire take  = first | live;
  wire last  = take & (cur_idx == LAST);

  assign cur_idx = first ? '0 : idx_q;
  assign phys_n  = byte_hit & (first | phys_q);
  assign bc_n    = (&rx_byte) & (first | bc_q);

  always_comb begin
    byte_hit = 1'b0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cur_idx == IDX_W'(i)) byte_hit = (rx_byte == sta_q[i]);
  end

  always_comb begin
    case (mode_q)
      2'd0:    verdict = 1'b0;
      2'd1:    verdict = phys_n;
      2'd2:    verdict = phys_n | bc_n;
      default: verdict = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ADDR_BYTES; i++) sta_q[i] <= '0;
      mode_q <= 2'd0;
    end else if (cfg_we) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (cfg_addr == 3'(i)) sta_q[i] <= cfg_wdata;
      if (cfg_addr == MODE_OFS) mode_q <= cfg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= IDLE;
      phys_q   <= 1'b0;
      bc_q     <= 1'b0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      if (take) begin
        idx_q  <= last ? IDLE : cur_idx + IDX_W'(1);
        phys_q <= phys_n;
        bc_q   <= bc_n;
      end
      done_q   <= last;
      accept_q <= last & verdict;
    end
  end

  assign dec_done   = done_q;
  assign dec_accept = accept_q;
endmodule

module rx_addr_filter_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       dec_done,
  input logic       dec_accept,
  input logic [1:0] mode
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done);
  p_accept_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_done);
  p_done_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> $past(rx_valid));
  p_off_rejects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && $past(mode) == 2'd0) |-> !dec_accept);
  p_promisc_accepts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && $past(mode) == 2'd3) |-> dec_accept);
endmodule

bind rx_addr_filter rx_addr_filter_checks u_checks (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
  .dec_done(dec_done), .dec_accept(dec_accept), .mode(mode_q)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, rx_byte = '0;
  logic dec_done, dec_accept;
  int errors = 0, checks = 0;
  logic [47:0] sta = 48'h021A3C4D5E6F;
  logic [1:0]  mode = 2'd0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_addr_filter dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    wr(3'd6, {6'd0, m}); mode = m;
  endtask

  function automatic bit expect_acc(input logic [47:0] da);
    case (mode)
      2'd0: return 1'b0;
      2'd1: return da == sta;
      2'd2: return (da == sta) || (da == '1);
      default: return 1'b1;
    endcase
  endfunction

  // sends n bytes of da (first byte = da[47:40]); returns whether done was seen
  task automatic bytes(input logic [47:0] da, input int n, input bit sof, input bit gaps, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dec_done) seen = 1;
      rx_valid = 1'b1; rx_sof = sof && (i == 0); rx_byte = da[47-8*i -: 8];
      if (gaps) begin
        @(negedge clk);
        if (dec_done) seen = 1;
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
    @(negedge clk);
    if (dec_done) seen = 1;
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  // full frame: checks done in the cycle after byte six, the verdict, and pulse width
  task automatic frame(input string tag, input logic [47:0] da, input bit gaps);
    bit early;
    early = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dec_done) early = 1;
      rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = da[47-8*i -: 8];
      if (gaps && i < 5) begin
        @(negedge clk);
        if (dec_done) early = 1;
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check(!early, {tag, " R6 no early done"}, early, 0);
    check(dec_done == 1'b1, {tag, " R6 done after sixth byte"}, dec_done, 1);
    check(dec_accept == expect_acc(da), {tag, " verdict"}, dec_accept, expect_acc(da));
    @(negedge clk);
    check(dec_done == 1'b0 && dec_accept == 1'b0, {tag, " R6 single pulse"}, {dec_done, dec_accept}, 0);
  endtask

  task automatic t_reset;
    bit seen;
    check(dec_done == 0 && dec_accept == 0, "R9 reset outputs", {dec_done, dec_accept}, 0);
    frame("R9 zero station mode0", 48'h0, 0);
    bytes(48'hFFFFFFFFFFFF, 6, 0, 0, seen);
    check(!seen, "R8 bytes before any sof ignored", seen, 0);
  endtask

  task automatic t_config;
    for (int i = 0; i < 6; i++) wr(3'(i), sta[47-8*i -: 8]);
    set_mode(2'd1);
  endtask

  task automatic t_mode1;
    frame("R3 exact match", sta, 0);
    frame("R3 last byte differs", sta ^ 48'h1, 0);
    frame("R3 first byte differs", sta ^ 48'h800000000000, 0);
    frame("R3 broadcast rejected", 48'hFFFFFFFFFFFF, 0);
    frame("R1 byte order reversed", 48'h6F5E4D3C1A02, 0);
    frame("R6 idle gaps between bytes", sta, 1);
  endtask

  task automatic t_single_reg;
    wr(3'd3, 8'hA5);
    sta[23:16] = 8'hA5;
    frame("R1 offset3 rewrite new value", sta, 0);
    frame("R1 offset3 old value rejected", {sta[47:24], 8'h4D, sta[15:0]}, 0);
  endtask

  task automatic t_modes;
    set_mode(2'd2);
    frame("R4 match", sta, 0);
    frame("R4 broadcast", 48'hFFFFFFFFFFFF, 0);
    frame("R4 other", 48'h123456789ABC, 0);
    frame("R4 near broadcast", 48'hFFFFFFFFFFFE, 0);
    set_mode(2'd3);
    frame("R5 promiscuous other", 48'h123456789ABC, 0);
    set_mode(2'd0);
    frame("R2 off rejects match", sta, 0);
    frame("R2 off rejects broadcast", 48'hFFFFFFFFFFFF, 0);
  endtask

  task automatic t_short_restart;
    bit seen;
    set_mode(2'd1);
    bytes(sta, 5, 1, 0, seen);
    repeat (8) begin
      @(negedge clk);
      if (dec_done) seen = 1;
    end
    check(!seen, "R8 five-byte frame no done", seen, 0);
    bytes(sta, 4, 1, 0, seen);
    check(!seen, "R7 partial frame no done", seen, 0);
    frame("R7 restart after partial", 48'h021A3CFFFFFF, 0);
    frame("R7 restart match", sta, 0);
    bytes(48'h112233445566, 6, 0, 0, seen);
    check(!seen, "R8 trailing bytes ignored", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_mode1();
    t_single_reg();
    t_modes();
    t_short_restart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule